// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes on an asynchronous serial line. Each frame has one low start bit, eight data bits sent least significant first, and one high stop bit. Each bit lasts 16 pulses of an external baud tick. A one-byte holding buffer sits in front of the shift register. Software can therefore load the next byte while the current frame is still going out, and consecutive frames leave the line with no idle time between them.

Software decides how much to write from two status flags. `buf_full` means a byte is waiting in the holding buffer. `shift_busy` means a frame is being serialized.

| `buf_full` | `shift_busy` | Bytes that may be written |
|---|---|---|
| 0 | 0 | two |
| 0 | 1 | one |
| 1 | either | none |

A one-cycle `tx_done` pulse marks the end of each frame's stop bit. After that pulse, software reads the flags again to decide its next writes.

A write made while the buffer is full is dropped and sets a sticky collision flag. A reinitialize request aborts the transmitter only once the holding buffer is empty. While the buffer is full, the request is held pending.

The shifter state machine has four states:

| State | Line level |
|---|---|
| `TX_IDLE` | high |
| `TX_START` | start bit, low |
| `TX_DATA` | the eight data bits |
| `TX_STOP` | stop bit, high |

Its transitions are:

| Transition | From | To | When |
|---|---|---|---|
| launch | `TX_IDLE` | `TX_START` | buffer holds a byte |
| start-done | `TX_START` | `TX_DATA` | the start bit ends |
| data-next | `TX_DATA` | `TX_DATA` | a data bit other than the last ends |
| data-done | `TX_DATA` | `TX_STOP` | the last data bit ends |
| chain | `TX_STOP` | `TX_START` | the stop bit ends and the buffer is full |
| finish | `TX_STOP` | `TX_IDLE` | the stop bit ends and the buffer is empty |
| abort | any state | `TX_IDLE` | a reinitialize request is honoured |

Top module: `uart_tx_dbuf`

## Requirements
- R1: The buffered byte moves into the shifter when a frame starts. `buf_full` drops on the same clock edge at which the shifter enters `TX_START`, whether starting from idle or chaining from the stop bit.
- R2: `buf_full` is 1 from the edge that accepts a write until the edge at which that byte moves into the shifter.
- R3: A write while `buf_full` is 1 is ignored and its data is never sent. It sets `wr_coll`, which stays set.
- R4: `wr_coll` resets to 0 and is cleared by a one-cycle `coll_clr` strobe. If a colliding write arrives in the same cycle as the strobe, the flag stays set.
- R5: `shift_busy` is 1 from the edge at which a frame starts until the edge at which the last stop bit ends, and 0 when the transmitter is idle.
- R6: `tx_done` is a single-cycle pulse. It is raised on the edge that ends each frame's stop bit.
- R7: On `txd`, a frame is a 0 start bit, then data bits 0 through 7, then a 1 stop bit. Each bit lasts 16 cycles in which `baud_tick` is 1, and cycles without a tick do not advance the frame.
- R8: If a byte is buffered when a stop bit ends, its start bit begins at the very next bit period, with no idle time between frames.
- R9: If `reinit_req` arrives while `buf_full` is 0, it is honoured on that edge. The shifter returns to idle, `txd` goes high, and no `tx_done` is produced for the aborted frame.
- R10: If `reinit_req` arrives while `buf_full` is 1, the request is held pending and the current frame continues. When the buffered byte moves out of the buffer, the request is honoured on that same edge. That byte is discarded, and the line stays high afterwards.
- R11: After reset, `txd` is 1 and `buf_full`, `shift_busy`, `tx_done` and `wr_coll` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Oversampling tick; 16 ticks make one bit |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| coll_clr | input | 1 | Clears `wr_coll` |
| reinit_req | input | 1 | Request to reinitialize the transmitter |
| txd | output | 1 | Serial line output |
| buf_full | output | 1 | Holding buffer occupied |
| shift_busy | output | 1 | A frame is being shifted out |
| tx_done | output | 1 | One-cycle pulse at the end of each frame |
| wr_coll | output | 1 | Sticky write-collision flag |

## Verification
Timing is counted from the edge that samples a stimulus:

| Stimulus | Result | When it is due |
|---|---|---|
| write | `buf_full` set | that edge |
| write, transmitter idle | shifter loaded, `buf_full` cleared, `shift_busy` set, start bit on `txd` | one edge later |
| each bit | next bit on `txd` | 16 ticks after the previous bit |
| stop bit ends | `tx_done` pulse, `shift_busy` clear | that same edge |
| honoured reinitialize | line high, `shift_busy` clear | that edge |
| colliding write | `wr_coll` set | that edge |

The bench drives inputs on falling edges and samples outputs on the falling edge after the due edge. Serial bits are sampled at the middle of each bit: it finds the first low sample of the start bit, then waits half a bit, then one whole bit per bit. The gap-free check samples the middle of the next start bit one bit period after the previous stop-bit middle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          coll_clr,
    input  logic          ld,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          coll
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (ld)
                full <= 1'b0;
            if (wr_en && !full) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            coll <= 1'b0;
        else if (wr_en && full)
            coll <= 1'b1;
        else if (coll_clr)
            coll <= 1'b0;
    end

    // R3: a write into a full buffer raises the collision flag
    p_coll_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> coll);

    // R2: an occupied buffer stays occupied until its byte is handed off
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !ld) |=> full);

    // R4: the collision flag only changes on a collision or a clear strobe
    p_coll_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (coll && !coll_clr) |=> coll);
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          buf_valid,
    input  logic [DW-1:0] buf_data,
    input  logic          abort_req,
    output logic          ld,
    output logic          abort_ack,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(DW - 1);

    tx_state_e     state, nxt;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [DW-1:0] sh;
    logic          bit_end;
    logic          load_now;
    logic          honour;

    assign bit_end  = tick && (cnt == CNT_LAST);
    assign load_now = buf_valid &&
                      ((state == TX_IDLE) || ((state == TX_STOP) && bit_end));
    assign honour   = abort_req && (!buf_valid || load_now);
    assign ld        = load_now;
    assign abort_ack = honour;

    always_comb begin
        nxt = state;
        if (honour) begin
            nxt = TX_IDLE;
        end else begin
            unique case (state)
                TX_IDLE:  if (buf_valid) nxt = TX_START;
                TX_START: if (bit_end) nxt = TX_DATA;
                TX_DATA:  if (bit_end && (idx == IDX_LAST)) nxt = TX_STOP;
                TX_STOP:  if (bit_end) nxt = buf_valid ? TX_START : TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= TX_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            idx  <= '0;
            sh   <= '0;
            done <= 1'b0;
        end else begin
            done <= (state == TX_STOP) && bit_end;
            if (load_now || honour)
                cnt <= '0;
            else if (tick)
                cnt <= bit_end ? '0 : cnt + 1'b1;
            if (load_now)
                sh <= buf_data;
            else if ((state == TX_DATA) && bit_end)
                sh <= {1'b0, sh[DW-1:1]};
            if (state == TX_START)
                idx <= '0;
            else if ((state == TX_DATA) && bit_end)
                idx <= idx + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_STOP:  txd = 1'b1;
        endcase
        busy = (state != TX_IDLE);
    end

    // R1: a handoff without abort always opens a start bit
    p_load_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !abort_ack) |=> (state == TX_START));

    // R6: frame-complete is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: without a tick the bit timer and state hold
    p_tick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_now && !honour) |=> ($stable(cnt) && $stable(state)));
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          coll_clr,
    input  logic          reinit_req,
    output logic          txd,
    output logic          buf_full,
    output logic          shift_busy,
    output logic          tx_done,
    output logic          wr_coll
);
    logic          ld;
    logic          abort_ack;
    logic          reinit_pend;
    logic [DW-1:0] buf_data;

    uart_tx_holdbuf #(.DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .coll_clr (coll_clr),
        .ld       (ld),
        .full     (buf_full),
        .data     (buf_data),
        .coll     (wr_coll)
    );

    uart_tx_shifter #(.DW(DW), .OVS(OVS)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .buf_valid (buf_full),
        .buf_data  (buf_data),
        .abort_req (reinit_req || reinit_pend),
        .ld        (ld),
        .abort_ack (abort_ack),
        .txd       (txd),
        .busy      (shift_busy),
        .done      (tx_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reinit_pend <= 1'b0;
        else if (abort_ack)
            reinit_pend <= 1'b0;
        else if (reinit_req)
            reinit_pend <= 1'b1;
    end

    // R10: a pending reinitialize does not stop a frame while the buffer is full
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit_pend && buf_full && shift_busy && !ld) |=> shift_busy);

    // R9: an honoured request leaves the transmitter idle
    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_ack |=> (!shift_busy && txd));
endmodule

// File: tb/test_uart_tx_dbuf.sv
module test_uart_tx_dbuf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       coll_clr = 1'b0;
    logic       reinit_req = 1'b0;
    logic       txd, buf_full, shift_busy, tx_done, wr_coll;
    logic       div2 = 1'b0;
    int         nchk = 0;
    int         nerr = 0;
    bit         ended = 0;

    always #5 clk = ~clk;

    always @(negedge clk)
        baud_tick <= div2 ? ~baud_tick : 1'b1;

    uart_tx_dbuf i_uart_tx_dbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .coll_clr   (coll_clr),
        .reinit_req (reinit_req),
        .txd        (txd),
        .buf_full   (buf_full),
        .shift_busy (shift_busy),
        .tx_done    (tx_done),
        .wr_coll    (wr_coll)
    );

    typedef struct packed {
        logic [7:0] d;
        logic [9:0] line;   // bit 0 is the start bit, bit 9 the stop bit
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'h55, 10'b1010101010},
        '{8'h00, 10'b1000000000},
        '{8'hFF, 10'b1111111110},
        '{8'h81, 10'b1100000010},
        '{8'h3C, 10'b1001111000},
        '{8'hA5, 10'b1101001010}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic recv_frame(input logic [9:0] pat, input bit synced, input int per, input string tag);
        if (!synced) begin
            int n = 0;
            while (txd !== 1'b0 && n < 400) begin
                @(negedge clk);
                n++;
            end
            chk({tag, " start seen"}, 32'(txd), 32'd0);
            repeat (per / 2) @(negedge clk);
        end
        for (int i = 0; i < 10; i++) begin
            chk($sformatf("%s bit %0d", tag, i), 32'(txd), 32'(pat[i]));
            if (i < 9) repeat (per) @(negedge clk);
        end
    endtask

    task automatic wait_done(input int lim, input bit exp_busy, input string tag);
        int n = 0;
        while (tx_done !== 1'b1 && n < lim) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R6 tx_done seen"}, 32'(tx_done), 32'd1);
        chk({tag, " R5 busy after stop"}, 32'(shift_busy), 32'(exp_busy));
        @(negedge clk);
        chk({tag, " R6 pulse width"}, 32'(tx_done), 32'd0);
    endtask

    task automatic idle_watch(input int cycles, input string tag);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txd !== 1'b1 || shift_busy !== 1'b0 || tx_done !== 1'b0) bad++;
        end
        chk({tag, " line stays idle"}, 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 txd", 32'(txd), 32'd1);
        chk("R11 buf_full", 32'(buf_full), 32'd0);
        chk("R11 shift_busy", 32'(shift_busy), 32'd0);
        chk("R11 tx_done", 32'(tx_done), 32'd0);
        chk("R11 wr_coll", 32'(wr_coll), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 / R1 / R2 / R5: single frames from the table
        foreach (VEC[k]) begin
            wr(VEC[k].d);
            chk("R2 full after write", 32'(buf_full), 32'd1);
            @(negedge clk);
            chk("R1 handoff clears full", 32'(buf_full), 32'd0);
            chk("R5 busy in frame", 32'(shift_busy), 32'd1);
            recv_frame(VEC[k].line, 1'b0, 16, "R7 table frame");
            wait_done(40, 1'b0, "table");
        end

        // R8 / R3 / R4: back-to-back bytes with a colliding third write
        wr(8'h5A);
        @(negedge clk);
        wr(8'hC3);
        chk("R2 second byte buffered", 32'(buf_full), 32'd1);
        chk("R5 busy with buffer", 32'(shift_busy), 32'd1);
        wr(8'hFF);
        chk("R3 collision flag", 32'(wr_coll), 32'd1);
        chk("R3 buffer still full", 32'(buf_full), 32'd1);
        recv_frame(10'b1010110100, 1'b0, 16, "R8 first");
        repeat (16) @(negedge clk);
        chk("R8 no gap start", 32'(txd), 32'd0);
        chk("R1 chained handoff", 32'(buf_full), 32'd0);
        recv_frame(10'b1110000110, 1'b1, 16, "R8 second");
        wait_done(40, 1'b0, "chain");
        idle_watch(200, "R3 dropped byte");
        chk("R3 sticky", 32'(wr_coll), 32'd1);
        @(negedge clk);
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;
        chk("R4 cleared", 32'(wr_coll), 32'd0);

        // R7: ticks every other cycle stretch each bit to 32 cycles
        div2 = 1'b1;
        wr(8'hA5);
        recv_frame(10'b1101001010, 1'b0, 32, "R7 slow tick");
        wait_done(80, 1'b0, "slow");
        div2 = 1'b0;
        repeat (4) @(negedge clk);

        // R9: reinitialize with an empty buffer aborts at once
        wr(8'h0F);
        repeat (40) @(negedge clk);
        reinit_req = 1'b1;
        @(negedge clk);
        reinit_req = 1'b0;
        chk("R9 busy cleared", 32'(shift_busy), 32'd0);
        chk("R9 line high", 32'(txd), 32'd1);
        idle_watch(200, "R9 after abort");

        // R10: reinitialize with a full buffer waits for the handoff
        wr(8'h96);
        @(negedge clk);
        wr(8'h11);
        reinit_req = 1'b1;
        @(negedge clk);
        reinit_req = 1'b0;
        chk("R10 buffer held", 32'(buf_full), 32'd1);
        chk("R10 frame continues", 32'(shift_busy), 32'd1);
        recv_frame(10'b1100101100, 1'b0, 16, "R10 frame");
        wait_done(40, 1'b0, "R10");
        chk("R10 buffer drained", 32'(buf_full), 32'd0);
        idle_watch(200, "R10 after abort");

        finish_run();
    end
endmodule